// File: doc/BRIEF.md
# Load/Store Address Watchpoint Comparator

This block watches bus load/store cycles and compares each cycle's 32-bit address against a programmed reference address. A watchpoint is meant to fire whether or not the access is aligned, so the low address bits that cannot matter for the access are masked. On a word access the bottom two bits are masked. On a half-word access only bit 0 is masked. On a byte access every bit takes part. Masked bits are cleared on both operands, and the two values are then compared as unsigned numbers.

The compare gives two raw results, equal and less-than, both with the cycle address on the left-hand side. These two results are reduced to one event according to a programmed compare type. The event is raised only when the cycle's read/write direction is one the direction field allows. A qualifying cycle produces a single registered pulse on the clock edge after its valid strobe. The pulse can then feed watchpoint, counter or debug logic elsewhere.

Top module: `ls_addr_wp`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives `evt_o` low on that edge.
- R2: `evt_o` is high for exactly the one clock after an edge where `cyc_vld_i` was high and the cycle qualified, and is low after any edge where `cyc_vld_i` was low.
- R3: Size encoding on `cyc_size_i`: 0 = byte, 1 = half-word, 2 = word, 3 = treated as word. On a word cycle, address bits [1:0] of both operands are ignored.
- R4: On a half-word cycle, only address bit 0 is ignored. Bit 1 takes part in the compare.
- R5: On a byte cycle, all 32 address bits take part in the compare.
- R6: Compare type encoding on `cmp_type_i`: 0 = equal, 1 = not equal, 2 = greater than, 3 = less than. The result is the masked cycle address compared against the masked reference address.
- R7: The compare is unsigned, so an address with bit 31 set is greater than one with bit 31 clear.
- R8: Greater than holds only when the addresses are neither equal nor less-than. Not equal is the inverse of equal.
- R9: Direction encoding on `dir_sel_i`: 1 = reads only, 2 = writes only, 3 = either, 0 = none. `cyc_wr_i` is high for a write. A cycle whose direction is not selected gives no event, whatever the address result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_vld_i | input | 1 | Load/store cycle strobe |
| cyc_addr_i | input | 32 | Cycle address |
| cyc_size_i | input | 2 | Access size |
| cyc_wr_i | input | 1 | 1 = write, 0 = read |
| ref_addr_i | input | 32 | Programmed reference address |
| dir_sel_i | input | 2 | Direction qualifier |
| cmp_type_i | input | 2 | Event selection |
| evt_o | output | 1 | Registered event pulse |

## Verification
The address-compare path and the direction qualifier act in the same cycle. A cycle can therefore satisfy the address condition while being blocked by its direction, or the reverse. The bench provokes this with random and directed cycles where an address that hits meets every direction setting. It expects a pulse only when both conditions agree.

Size masking and the compare type also meet in one cycle. The bench places addresses that differ only in the masked bits under every compare type and checks that equal and not-equal swap at the mask boundary.

// File: rtl/ls_addr_wp_pkg.sv
package ls_addr_wp_pkg;
  localparam int AW = 32;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} size_e;
  typedef enum logic [1:0] {CT_EQ = 2'd0, CT_NE = 2'd1, CT_GT = 2'd2, CT_LT = 2'd3} cmp_e;

  function automatic logic [AW-1:0] size_mask(input logic [1:0] sz);
    logic [AW-1:0] m;
    m = '1;
    case (sz)
      2'd0:    m = '1;
      2'd1:    m[0] = 1'b0;
      default: m[1:0] = 2'b00;
    endcase
    return m;
  endfunction

  function automatic logic pick_event(input logic eq, input logic lt, input logic [1:0] ct);
    logic r;
    case (ct)
      2'd0:    r = eq;
      2'd1:    r = !eq;
      2'd2:    r = !eq && !lt;
      default: r = lt;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ls_addr_cmp_core.sv
module ls_addr_cmp_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] mask_i,
  output logic         eq_o,
  output logic         lt_o
);
  logic [W-1:0] am, bm;
  assign am   = a_i & mask_i;
  assign bm   = b_i & mask_i;
  assign eq_o = (am == bm);
  assign lt_o = (am < bm);
endmodule

// File: rtl/ls_dir_qual.sv
module ls_dir_qual (
  input  logic [1:0] dir_sel_i,
  input  logic       wr_i,
  output logic       ok_o
);
  assign ok_o = wr_i ? dir_sel_i[1] : dir_sel_i[0];
endmodule

// File: rtl/ls_addr_wp.sv
module ls_addr_wp
  import ls_addr_wp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cyc_vld_i,
  input  logic [31:0] cyc_addr_i,
  input  logic [1:0]  cyc_size_i,
  input  logic        cyc_wr_i,
  input  logic [31:0] ref_addr_i,
  input  logic [1:0]  dir_sel_i,
  input  logic [1:0]  cmp_type_i,
  output logic        evt_o
);
  logic [AW-1:0] mask_w;
  logic          raw_eq_w;
  logic          raw_lt_w;
  logic          dir_ok_w;
  logic          hit_w;
  logic          evt_q;

  assign mask_w = size_mask(cyc_size_i);

  ls_addr_cmp_core #(.W(AW)) u_cmp (
    .a_i   (cyc_addr_i),
    .b_i   (ref_addr_i),
    .mask_i(mask_w),
    .eq_o  (raw_eq_w),
    .lt_o  (raw_lt_w)
  );

  ls_dir_qual u_dir (
    .dir_sel_i(dir_sel_i),
    .wr_i     (cyc_wr_i),
    .ok_o     (dir_ok_w)
  );

  assign hit_w = cyc_vld_i && dir_ok_w && pick_event(raw_eq_w, raw_lt_w, cmp_type_i);

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= hit_w;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/ls_addr_wp_chk.sv
module ls_addr_wp_chk (
  input logic        clk,
  input logic        rst,
  input logic        cyc_vld_i,
  input logic [31:0] cyc_addr_i,
  input logic [1:0]  cyc_size_i,
  input logic        cyc_wr_i,
  input logic [31:0] ref_addr_i,
  input logic [1:0]  dir_sel_i,
  input logic        raw_eq_w,
  input logic        raw_lt_w,
  input logic        evt_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !evt_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !cyc_vld_i |=> !evt_o);
  // R8
  eq_lt_excl_chk: assert property (@(posedge clk) disable iff (rst) !(raw_eq_w && raw_lt_w));
  // R9
  dir_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_vld_i && ((cyc_wr_i && !dir_sel_i[1]) || (!cyc_wr_i && !dir_sel_i[0]))) |=> !evt_o);
  // R3
  word_low_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_size_i[1] && cyc_addr_i[31:2] == ref_addr_i[31:2]) |-> raw_eq_w);
  // R5
  byte_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_size_i == 2'd0) |-> (raw_eq_w == (cyc_addr_i == ref_addr_i)));
endmodule

bind ls_addr_wp ls_addr_wp_chk u_chk (
  .clk(clk), .rst(rst), .cyc_vld_i(cyc_vld_i), .cyc_addr_i(cyc_addr_i),
  .cyc_size_i(cyc_size_i), .cyc_wr_i(cyc_wr_i), .ref_addr_i(ref_addr_i),
  .dir_sel_i(dir_sel_i), .raw_eq_w(raw_eq_w), .raw_lt_w(raw_lt_w), .evt_o(evt_o)
);

// File: tb/ls_addr_wp_test.sv
module ls_addr_wp_test;
  localparam time TCK = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  sz = '0;
  logic        wr = 1'b0;
  logic [31:0] refa = '0;
  logic [1:0]  dsel = 2'd3;
  logic [1:0]  ct = '0;
  logic        evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  ls_addr_wp uut (
    .clk(clk), .rst(rst), .cyc_vld_i(vld), .cyc_addr_i(addr), .cyc_size_i(sz),
    .cyc_wr_i(wr), .ref_addr_i(refa), .dir_sel_i(dsel), .cmp_type_i(ct), .evt_o(evt)
  );

  function automatic bit model(bit v, logic [31:0] a, logic [31:0] r, logic [1:0] s,
                               bit w, logic [1:0] d, logic [1:0] t);
    logic [31:0] ka, kr;
    int drop;
    bit dok, e, l, res;
    drop = (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
    ka = (a >> drop) << drop;
    kr = (r >> drop) << drop;
    e = (ka == kr);
    l = (ka < kr);
    dok = w ? d[1] : d[0];
    case (t)
      2'd0: res = e;
      2'd1: res = !e;
      2'd2: res = !(e || l);
      default: res = l;
    endcase
    return v && dok && res;
  endfunction

  task automatic check(string req, bit exp);
    n_chk++;
    if (evt !== exp) begin
      n_bad++;
      $display("FAIL %s: evt=%b expected %b", req, evt, exp);
    end
  endtask

  task automatic apply(string req, bit v, logic [31:0] a, logic [31:0] r, logic [1:0] s,
                       bit w, logic [1:0] d, logic [1:0] t);
    bit exp;
    vld = v; addr = a; refa = r; sz = s; wr = w; dsel = d; ct = t;
    exp = model(v, a, r, s, w, d, t);
    @(posedge clk);
    #(TCK/4);
    check(req, exp);
    vld = 0;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    vld = 1;
    repeat (2) @(posedge clk);
    #(TCK/4);
    check("R1", 1'b0);
    rst = 0;
    vld = 0;
    @(posedge clk);
    #(TCK/4);
    check("R2", 1'b0);

    // R3 word: low bits ignored
    apply("R3", 1, 32'h1000_0003, 32'h1000_0000, 2'd2, 0, 2'd3, 2'd0); // hit
    apply("R3", 1, 32'h1000_0003, 32'h1000_0000, 2'd3, 0, 2'd3, 2'd1); // ne false
    apply("R3", 1, 32'h1000_0004, 32'h1000_0000, 2'd2, 0, 2'd3, 2'd0);
    // R4 half-word
    apply("R4", 1, 32'h2000_0001, 32'h2000_0000, 2'd1, 1, 2'd3, 2'd0);
    apply("R4", 1, 32'h2000_0002, 32'h2000_0000, 2'd1, 1, 2'd3, 2'd0);
    apply("R4", 1, 32'h2000_0002, 32'h2000_0000, 2'd1, 1, 2'd3, 2'd2);
    // R5 byte
    apply("R5", 1, 32'h3000_0001, 32'h3000_0000, 2'd0, 0, 2'd3, 2'd0);
    apply("R5", 1, 32'h3000_0001, 32'h3000_0000, 2'd0, 0, 2'd3, 2'd1);
    // R6 / R8 types
    apply("R6", 1, 32'h0000_0100, 32'h0000_0200, 2'd0, 0, 2'd3, 2'd3);
    apply("R8", 1, 32'h0000_0100, 32'h0000_0200, 2'd0, 0, 2'd3, 2'd2);
    apply("R8", 1, 32'h0000_0200, 32'h0000_0200, 2'd0, 0, 2'd3, 2'd2);
    apply("R6", 1, 32'h0000_0300, 32'h0000_0200, 2'd0, 0, 2'd3, 2'd2);
    // R7 unsigned
    apply("R7", 1, 32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 0, 2'd3, 2'd2);
    apply("R7", 1, 32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 0, 2'd3, 2'd3);
    // R9 direction
    apply("R9", 1, 32'h4000_0000, 32'h4000_0000, 2'd2, 1, 2'd1, 2'd0);
    apply("R9", 1, 32'h4000_0000, 32'h4000_0000, 2'd2, 0, 2'd2, 2'd0);
    apply("R9", 1, 32'h4000_0000, 32'h4000_0000, 2'd2, 1, 2'd2, 2'd0);
    apply("R9", 1, 32'h4000_0000, 32'h4000_0000, 2'd2, 0, 2'd0, 2'd0);
    // R2 no strobe, pulse is single
    apply("R2", 0, 32'h4000_0000, 32'h4000_0000, 2'd2, 0, 2'd3, 2'd0);
    apply("R2", 1, 32'h5000_0000, 32'h5000_0000, 2'd2, 0, 2'd3, 2'd0);
    @(posedge clk);
    #(TCK/4);
    check("R2", 1'b0);

    begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 2000; i++) begin
        logic [31:0] r, a;
        r = $urandom;
        case ($urandom_range(0, 3))
          0: a = r;
          1: a = r ^ ($urandom_range(0, 3));
          2: a = r ^ (32'h1 << $urandom_range(0, 31));
          default: a = $urandom;
        endcase
        apply("R6", $urandom_range(0, 7) != 0, a, r, 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule